// File: doc/BRIEF.md
# Forwarded-Clock Word Deserializer

This block turns a serial bit stream into 12-bit parallel words. The stream comes with a forwarded bit clock, modelled here as a one-cycle bit-valid enable in the local clock domain. Every bit is taken on that enable, and no clock is recovered locally. A word travels in a 14-slot frame: a one start bit, twelve data bits with the most significant bit first, then a zero stop bit. When the sender's reference clock ran faster than its strobe, zero filler slots sit between frames. Filler slots never produce a word.

Each accepted word appears on the parallel bus with a one-cycle valid pulse. In the same cycle a regenerated word clock rises, so the word clock runs at the sender's strobe rate. The word clock stays high for the measured word period minus a parameterised count of slots, which stands for half a reference period. This shapes the duty cycle from the strobe-to-reference ratio. Two select inputs drive every output low when both are low. A direction input that selects serialize freezes the receive path.

Top module: `fcw_deser`

## Requirements
- R1: A frame starts with a 1 bit taken while idle. It is followed by 12 data bits, most significant bit first, and then a 0 stop bit. The 12 data bits appear on word_o.
- R2: Zero bits taken while idle are filler. They produce no word, no error and no change to word_o.
- R3: Only cycles with bit_en_i high carry bits. Cycles with bit_en_i low have no effect on framing, word timing or the word clock.
- R4: When the stop bit is 1, frame_err_o pulses high for one cycle. No word is produced, and word_o keeps its previous value.
- R5: word_vld_o pulses high for one cycle, in the cycle after the enable that carried the stop bit. word_clk_o is high in that cycle.
- R6: After a word, word_clk_o stays high for exactly (P - HALF_SLOTS) enabled slots, then goes low. P is the slot count from the previous word's stop bit to this one, with P = 14 for the first word after reset. The high time is at least one slot. With HALF_SLOTS = 7 and back-to-back frames, the high time is 7 slots.
- R7: While sel_a_i and sel_b_i are both low, word_o, word_vld_o, word_clk_o and frame_err_o are all 0.
- R8: While dir_ser_i is 1, serial input is ignored. word_o and word_clk_o hold their values, and no valid or error pulse occurs.
- R9: After reset, word_o is 0 and word_vld_o, word_clk_o and frame_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | Forwarded bit clock as a one-cycle bit-valid enable |
| ser_i | input | 1 | Serial data, sampled when bit_en_i is high |
| dir_ser_i | input | 1 | 1 selects serialize and freezes the receive path |
| sel_a_i | input | 1 | Mode select A |
| sel_b_i | input | 1 | Mode select B; both selects low force all outputs low |
| word_o | output | 12 | Last received word |
| word_vld_o | output | 1 | One-cycle pulse marking a new word |
| word_clk_o | output | 1 | Regenerated word clock |
| frame_err_o | output | 1 | One-cycle pulse on a frame with a bad stop bit |

## Verification
The bench first sends back-to-back frames with distinct bit patterns. This shows whether the bits are ordered most significant first, and confirms the 7-slot high time when frame and word periods are equal. It then sends frames separated by six filler slots, which shows whether the filler is skipped and whether the high time stretches to 13 slots. Enables spaced two idle cycles apart show whether only enabled cycles count. A bad stop bit, both selects low, and serialize direction each show whether an output is suppressed or held rather than updated.

// File: rtl/fcw_deser_pkg.sv
package fcw_deser_pkg;
    localparam int DATA_W      = 12;
    localparam int FRAME_SLOTS = DATA_W + 2;
    localparam int SLOT_CW     = $clog2(DATA_W + 1);

    typedef struct packed {
        logic               busy;
        logic [SLOT_CW-1:0] cnt;
        logic [DATA_W-1:0]  sh;
    } rx_state_t;
endpackage

// File: rtl/fcw_frame_rx.sv
module fcw_frame_rx
    import fcw_deser_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] word_o
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        err_o  = 1'b0;
        word_o = st_q.sh;
        if (en_i) begin
            if (!st_q.busy) begin
                if (bit_i) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                end
            end else if (st_q.cnt != SLOT_CW'(DATA_W)) begin
                st_d.sh  = {st_q.sh[DATA_W-2:0], bit_i};
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.busy = 1'b0;
                done_o    = ~bit_i;
                err_o     = bit_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/fcw_wclk_gen.sv
module fcw_wclk_gen #(
    parameter int FRAME_SLOTS = 14,
    parameter int HALF_SLOTS  = 7,
    parameter int CNT_W       = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic done_i,
    output logic wclk_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] ivl;
        logic [CNT_W-1:0] rem;
        logic             seen;
        logic             clk;
    } wc_state_t;

    wc_state_t st_d, st_q;
    logic [CNT_W:0] period;

    always_comb begin
        st_d   = st_q;
        period = st_q.seen ? ({1'b0, st_q.ivl} + 1'b1) : (CNT_W+1)'(FRAME_SLOTS);
        if (en_i) begin
            if (done_i) begin
                st_d.ivl  = '0;
                st_d.seen = 1'b1;
                st_d.clk  = 1'b1;
                if (period > (CNT_W+1)'(HALF_SLOTS))
                    st_d.rem = CNT_W'(period - (CNT_W+1)'(HALF_SLOTS));
                else
                    st_d.rem = CNT_W'(1);
            end else begin
                if (st_q.ivl != CNT_MAX) st_d.ivl = st_q.ivl + 1'b1;
                if (st_q.clk) begin
                    if (st_q.rem <= CNT_W'(1)) begin
                        st_d.clk = 1'b0;
                        st_d.rem = '0;
                    end else begin
                        st_d.rem = st_q.rem - 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign wclk_o = st_q.clk;
endmodule

// File: rtl/fcw_deser.sv
module fcw_deser
    import fcw_deser_pkg::*;
#(
    parameter int HALF_SLOTS = 7,
    parameter int CNT_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_en_i,
    input  logic              ser_i,
    input  logic              dir_ser_i,
    input  logic              sel_a_i,
    input  logic              sel_b_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              word_clk_o,
    output logic              frame_err_o
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              vld;
        logic              err;
    } out_state_t;

    out_state_t o_d, o_q;
    logic              rx_en, rx_done, rx_err, wclk, sel_on;
    logic [DATA_W-1:0] rx_word;

    assign rx_en  = bit_en_i & ~dir_ser_i;
    assign sel_on = sel_a_i | sel_b_i;

    fcw_frame_rx u_rx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (rx_en),
        .bit_i  (ser_i),
        .done_o (rx_done),
        .err_o  (rx_err),
        .word_o (rx_word)
    );

    fcw_wclk_gen #(
        .FRAME_SLOTS (FRAME_SLOTS),
        .HALF_SLOTS  (HALF_SLOTS),
        .CNT_W       (CNT_W)
    ) u_wclk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (rx_en),
        .done_i (rx_done),
        .wclk_o (wclk)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = rx_done;
        o_d.err = rx_err;
        if (rx_done) o_d.word = rx_word;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign word_o      = sel_on ? o_q.word : '0;
    assign word_vld_o  = sel_on & o_q.vld;
    assign word_clk_o  = sel_on & wclk;
    assign frame_err_o = sel_on & o_q.err;
endmodule

// File: rtl/fcw_deser_chk.sv
module fcw_deser_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        bit_en_i,
    input logic        dir_ser_i,
    input logic        sel_a_i,
    input logic        sel_b_i,
    input logic [11:0] word_o,
    input logic        word_vld_o,
    input logic        word_clk_o,
    input logic        frame_err_o
);
    logic sel_on;
    assign sel_on = sel_a_i | sel_b_i;

    p_vld_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_o |=> !word_vld_o);

    p_vld_with_clk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_o |-> word_clk_o);

    p_rise_needs_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(word_clk_o) && $past(sel_on)) |-> word_vld_o);

    p_no_bit_no_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> !(word_vld_o || frame_err_o));

    p_err_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(word_vld_o && frame_err_o));

    p_force_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_on |-> (word_o == '0 && !word_vld_o && !word_clk_o && !frame_err_o));

    p_hold_ser_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(dir_ser_i) && sel_on && $past(sel_on)) |-> ($stable(word_o) && $stable(word_clk_o)));
endmodule

bind fcw_deser fcw_deser_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .dir_ser_i   (dir_ser_i),
    .sel_a_i     (sel_a_i),
    .sel_b_i     (sel_b_i),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o),
    .word_clk_o  (word_clk_o),
    .frame_err_o (frame_err_o)
);

// File: tb/fcw_deser_test.sv
module fcw_deser_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0, ser = 1'b0, dir_ser = 1'b0;
    logic        sel_a = 1'b1, sel_b = 1'b0;
    logic [11:0] word;
    logic        vld, wclk, ferr;

    int n_chk = 0, n_bad = 0;
    int n_words = 0, n_err = 0, run = 0, last_high = 0;
    logic [11:0] last_word = '0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    fcw_deser uut (
        .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .ser_i(ser),
        .dir_ser_i(dir_ser), .sel_a_i(sel_a), .sel_b_i(sel_b),
        .word_o(word), .word_vld_o(vld), .word_clk_o(wclk), .frame_err_o(ferr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: collects words, errors and word-clock high runs
    always @(negedge clk) begin
        if (rst_n) begin
            if (vld) begin
                n_words++;
                last_word = word;
                chk(wclk == 1'b1, "R5 clock high with valid", int'(wclk), 1);
            end
            if (ferr) n_err++;
            if (wclk) run++;
            else if (run > 0) begin
                last_high = run;
                run = 0;
            end
        end
    end

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        ser = b; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_frame(input logic [11:0] w, input logic stop, input int gap);
        bit_en = 1'b1; ser = 1'b1;
        @(negedge clk);
        for (int i = 11; i >= 0; i--) begin
            ser = w[i];
            @(negedge clk);
        end
        ser = stop;
        @(negedge clk);
        bit_en = 1'b0; ser = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic filler(input int n);
        bit_en = 1'b1; ser = 1'b0;
        repeat (n) @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(word == 12'h000, "R9 word after reset", word, 0);
        chk({vld, wclk, ferr} == 3'b000, "R9 strobes after reset", {vld, wclk, ferr}, 0);
    endtask

    task automatic t_back_to_back;
        int w0;
        w0 = n_words;
        // continuous 14-slot frames, R1 bit order and R6 7-slot high time
        bit_en = 1'b1;
        for (int f = 0; f < 3; f++) begin
            logic [11:0] w;
            w = (f == 0) ? 12'hA5C : (f == 1) ? 12'h801 : 12'h3E7;
            ser = 1'b1; @(negedge clk);
            for (int i = 11; i >= 0; i--) begin ser = w[i]; @(negedge clk); end
            ser = 1'b0; @(negedge clk);
        end
        filler(30);
        chk(n_words - w0 == 3, "R1 word count", n_words - w0, 3);
        chk(last_word == 12'h3E7, "R1 last word msb first", last_word, 12'h3E7);
        chk(word == 12'h3E7, "R1 word_o holds", word, 12'h3E7);
        chk(last_high == 7, "R6 high time equal rates", last_high, 7);
    endtask

    task automatic t_filler;
        int w0;
        w0 = n_words;
        bit_en = 1'b1;
        for (int f = 0; f < 3; f++) begin
            logic [11:0] w;
            w = (f == 0) ? 12'h111 : (f == 1) ? 12'hFFE : 12'h6C9;
            ser = 1'b1; @(negedge clk);
            for (int i = 11; i >= 0; i--) begin ser = w[i]; @(negedge clk); end
            ser = 1'b0; @(negedge clk);
            repeat (6) @(negedge clk);  // R2 filler slots
        end
        filler(30);
        chk(n_words - w0 == 3, "R2 filler makes no word", n_words - w0, 3);
        chk(last_word == 12'h6C9, "R2 word across filler", last_word, 12'h6C9);
        chk(last_high == 13, "R6 high time with filler", last_high, 13);
        chk(n_err == 0, "R2 filler makes no error", n_err, 0);
    endtask

    task automatic t_gapped;
        send_frame(12'hC3A, 1'b0, 0);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 2);
        chk(last_word == 12'hC3A, "R3 gapped enables", last_word, 12'hC3A);
        // idle cycles with data toggling but no enable
        ser = 1'b1;
        repeat (20) @(negedge clk);
        ser = 1'b0;
        chk(word == 12'hC3A, "R3 no enable no change", word, 12'hC3A);
        filler(20);
    endtask

    task automatic t_bad_stop;
        int w0, e0;
        w0 = n_words; e0 = n_err;
        send_frame(12'h333, 1'b1, 0);
        filler(10);
        chk(n_err - e0 == 1, "R4 error pulse", n_err - e0, 1);
        chk(n_words == w0, "R4 no word", n_words - w0, 0);
        chk(word == 12'hC3A, "R4 word holds", word, 12'hC3A);
    endtask

    task automatic t_force_low;
        int w0;
        w0 = n_words;
        sel_a = 1'b0; sel_b = 1'b0;
        send_frame(12'h5A5, 1'b0, 0);
        chk(word == 12'h000, "R7 word forced low", word, 0);
        filler(3);
        chk({vld, wclk, ferr} == 3'b000, "R7 strobes forced low", {vld, wclk, ferr}, 0);
        chk(n_words == w0, "R7 no visible valid", n_words - w0, 0);
        sel_b = 1'b1;
        @(negedge clk);
        chk(word == 12'h5A5, "R7 word visible again", word, 12'h5A5);
        filler(20);
    endtask

    task automatic t_dir_ser;
        int w0, e0;
        w0 = n_words; e0 = n_err;
        dir_ser = 1'b1;
        send_frame(12'h0F0, 1'b0, 0);
        send_frame(12'h0F0, 1'b1, 0);
        filler(5);
        chk(n_words == w0, "R8 no word in serialize", n_words - w0, 0);
        chk(n_err == e0, "R8 no error in serialize", n_err - e0, 0);
        chk(word == 12'h5A5, "R8 word holds", word, 12'h5A5);
        dir_ser = 1'b0;
        send_frame(12'h9B2, 1'b0, 2);
        chk(word == 12'h9B2, "R8 receive resumes", word, 12'h9B2);
        filler(20);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_back_to_back();
        t_filler();
        t_gapped();
        t_bad_stop();
        t_force_low();
        t_dir_ser();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule